// File: doc/BRIEF.md
# Banked Display Memory Write Address Counter

This block keeps the write position into a display memory organised as five banks of 101 bytes. One byte holds eight stacked pixel lines of a single column, so a bank covers eight lines of the panel. Bank `b` carries lines 8b through 8b+7, and the least significant bit of each byte is the top line of that group. A host sets the column (0..100) and the bank (0..4) through two separate load strobes. Both values are write-only: the only way to read them is the position outputs.

Each data write request produces a one-cycle write enable towards the memory. The enable carries the byte and the flat address `bank*101 + column` of the current position. After that the position advances by one. In column-first order the column advances, and it rolls into the next bank after column 100. In bank-first order the bank advances, and it rolls into the next column after bank 4. The final cell (column 100, bank 4) rolls to (0, 0) in either order. Out-of-range load values are forced to zero.

The memory array, the serial host protocol and display scan-out are outside this block.

Top module: `disp_addr_ctr`

## Requirements
- R1: After reset, the column and the bank are both 0 and `mem_we` is low.
- R2: Pulsing `ld_col` loads `col_in` into the column. The new value shows on `cur_col` one cycle later. A value above 100 loads 0 instead.
- R3: Pulsing `ld_bank` loads `bank_in` into the bank. The new value shows on `cur_bank` one cycle later. A value above 4 loads 0 instead.
- R4: A cycle with `wr_req` high is followed by exactly one cycle of `mem_we` high. In that cycle `mem_addr` equals bank*101+column taken from the position before the step, and `mem_data` equals `wr_data`.
- R5: With `step_dir` = 0 (column first), each write adds one to the column. A write at column 100 sets the column to 0 and adds one to the bank.
- R6: With `step_dir` = 1 (bank first), each write adds one to the bank. A write at bank 4 sets the bank to 0 and adds one to the column.
- R7: A write at column 100, bank 4 leaves the position at column 0, bank 0 in both orders. This means 505 writes in a row return to the starting position.
- R8: A cycle without `wr_req` gives `mem_we` low in the next cycle and leaves the position unchanged.
- R9: If a load and a write happen in the same cycle, the write uses the position from before the load. The loaded field takes the load value, and the other field steps as it would for that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_col | input | 1 | Column load strobe |
| col_in | input | 7 | Column value to load |
| ld_bank | input | 1 | Bank load strobe |
| bank_in | input | 3 | Bank value to load |
| step_dir | input | 1 | 0 = column first, 1 = bank first |
| wr_req | input | 1 | Data byte write request |
| wr_data | input | 8 | Data byte |
| mem_we | output | 1 | Memory write enable, one cycle per request |
| mem_addr | output | 9 | Flat memory address bank*101+column |
| mem_data | output | 8 | Byte to write |
| cur_col | output | 7 | Current column |
| cur_bank | output | 3 | Current bank |

## Verification
Every result of this block lands one register stage after its stimulus. The write enable, address and byte for a request sampled at one rising edge are present from the next edge onward. Loaded or stepped positions likewise appear on `cur_col`/`cur_bank` after that one edge. The bench drives inputs just after a rising edge and records, at the same edge the design samples, whether a request was accepted. At the following falling edge it either pops the queued expected write and compares it, or requires `mem_we` to be low. Position checks are made at falling edges once the last stimulus has passed one edge.

// File: rtl/disp_addr_pkg.sv
package disp_addr_pkg;

   typedef enum logic {
      ORDER_COL_FIRST  = 1'b0,
      ORDER_BANK_FIRST = 1'b1
   } step_order_e;

   function automatic int unsigned span_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/wrap_field.sv
module wrap_field #(
   parameter int W    = 7,
   parameter int LAST = 100
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   output logic [W-1:0] value,
   output logic         at_last
);

   localparam logic [W-1:0] LAST_V = W'(LAST);

   generate
      if (LAST >= (1 << W)) begin : g_bad_width
         $error("wrap_field: LAST does not fit in W bits");
      end
      if (LAST < 1) begin : g_bad_last
         $error("wrap_field: LAST must be at least 1");
      end
   endgenerate

   logic [W-1:0] nxt;

   assign at_last = (value == LAST_V);

   always_comb begin
      nxt = value;
      if (load)
         nxt = (load_val > LAST_V) ? '0 : load_val;
      else if (step)
         nxt = at_last ? '0 : W'(value + 1'b1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) value <= '0;
      else        value <= nxt;
   end

   p_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      value <= LAST_V);

   p_load_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val > LAST_V) |=> (value == '0));

   p_step_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && at_last) |=> (value == '0));

   p_step_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !at_last) |=> (value == W'($past(value) + 1'b1)));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(value));

endmodule

// File: rtl/flat_addr.sv
module flat_addr #(
   parameter int COL_W     = 7,
   parameter int BANK_W    = 3,
   parameter int ADDR_W    = 9,
   parameter int COLS      = 101,
   parameter int BANKS     = 5,
   parameter bit USE_TABLE = 1'b1
) (
   input  logic [COL_W-1:0]  col,
   input  logic [BANK_W-1:0] bank,
   output logic [ADDR_W-1:0] addr
);

   generate
      if (COLS * BANKS > (1 << ADDR_W)) begin : g_bad_addr
         $error("flat_addr: ADDR_W too narrow for COLS*BANKS");
      end
   endgenerate

   logic [ADDR_W-1:0] base;

   generate
      if (USE_TABLE) begin : g_table
         logic [ADDR_W-1:0] base_tab [BANKS];
         for (genvar b = 0; b < BANKS; b++) begin : g_base
            assign base_tab[b] = ADDR_W'(b * COLS);
         end
         always_comb begin
            base = '0;
            for (int i = 0; i < BANKS; i++)
               if (bank == BANK_W'(i)) base = base_tab[i];
         end
      end else begin : g_mult
         assign base = ADDR_W'(ADDR_W'(bank) * ADDR_W'(COLS));
      end
   endgenerate

   assign addr = ADDR_W'(base + ADDR_W'(col));

endmodule

// File: rtl/wr_stage.sv
module wr_stage #(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   output logic              we,
   output logic [ADDR_W-1:0] addr_out,
   output logic [DATA_W-1:0] data_out
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we       <= 1'b0;
         addr_out <= '0;
         data_out <= '0;
      end else begin
         we <= req;
         if (req) begin
            addr_out <= addr_in;
            data_out <= data_in;
         end
      end
   end

   p_we_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> (we && addr_out == $past(addr_in) && data_out == $past(data_in)));

   p_we_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> !we);

endmodule

// File: rtl/disp_addr_ctr.sv
module disp_addr_ctr
   import disp_addr_pkg::*;
#(
   parameter int COLS      = 101,
   parameter int BANKS     = 5,
   parameter int COL_W     = 7,
   parameter int BANK_W    = 3,
   parameter int DATA_W    = 8,
   parameter bit USE_TABLE = 1'b1,
   localparam int ADDR_W   = span_bits(COLS * BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_col,
   input  logic [COL_W-1:0]  col_in,
   input  logic              ld_bank,
   input  logic [BANK_W-1:0] bank_in,
   input  logic              step_dir,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wr_data,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_data,
   output logic [COL_W-1:0]  cur_col,
   output logic [BANK_W-1:0] cur_bank
);

   localparam int COL_LAST  = COLS - 1;
   localparam int BANK_LAST = BANKS - 1;

   generate
      if (COLS < 2 || BANKS < 2) begin : g_bad_dims
         $error("disp_addr_ctr: need at least two columns and two banks");
      end
   endgenerate

   step_order_e order;
   logic col_last, bank_last;
   logic col_step, bank_step;
   logic [ADDR_W-1:0] flat;

   assign order = step_order_e'(step_dir);

   always_comb begin
      col_step  = 1'b0;
      bank_step = 1'b0;
      if (wr_req) begin
         unique case (order)
            ORDER_COL_FIRST: begin
               col_step  = 1'b1;
               bank_step = col_last;
            end
            ORDER_BANK_FIRST: begin
               bank_step = 1'b1;
               col_step  = bank_last;
            end
         endcase
      end
   end

   wrap_field #(.W(COL_W), .LAST(COL_LAST)) u_col (
      .clk(clk), .rst_n(rst_n), .load(ld_col), .load_val(col_in),
      .step(col_step), .value(cur_col), .at_last(col_last)
   );

   wrap_field #(.W(BANK_W), .LAST(BANK_LAST)) u_bank (
      .clk(clk), .rst_n(rst_n), .load(ld_bank), .load_val(bank_in),
      .step(bank_step), .value(cur_bank), .at_last(bank_last)
   );

   flat_addr #(
      .COL_W(COL_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W),
      .COLS(COLS), .BANKS(BANKS), .USE_TABLE(USE_TABLE)
   ) u_flat (
      .col(cur_col), .bank(cur_bank), .addr(flat)
   );

   wr_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
      .clk(clk), .rst_n(rst_n), .req(wr_req), .addr_in(flat), .data_in(wr_data),
      .we(mem_we), .addr_out(mem_addr), .data_out(mem_data)
   );

   p_corner_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !ld_col && !ld_bank && col_last && bank_last)
      |=> (cur_col == '0 && cur_bank == '0));

   p_col_first_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !step_dir && !ld_col && !ld_bank && col_last && !bank_last)
      |=> (cur_col == '0 && cur_bank == BANK_W'($past(cur_bank) + 1'b1)));

   p_bank_first_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && step_dir && !ld_col && !ld_bank && bank_last && !col_last)
      |=> (cur_bank == '0 && cur_col == COL_W'($past(cur_col) + 1'b1)));

   p_addr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr < ADDR_W'(COLS * BANKS)));

endmodule

// File: tb/sim_disp_addr_ctr.sv
module sim_disp_addr_ctr;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ld_col = 1'b0, ld_bank = 1'b0, step_dir = 1'b0, wr_req = 1'b0;
   logic [6:0] col_in = '0;
   logic [2:0] bank_in = '0;
   logic [7:0] wr_data = '0;
   logic       mem_we;
   logic [8:0] mem_addr;
   logic [7:0] mem_data;
   logic [6:0] cur_col;
   logic [2:0] cur_bank;

   always #2.5 clk = ~clk;

   disp_addr_ctr u0 (
      .clk(clk), .rst_n(rst_n), .ld_col(ld_col), .col_in(col_in),
      .ld_bank(ld_bank), .bank_in(bank_in), .step_dir(step_dir),
      .wr_req(wr_req), .wr_data(wr_data), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_data(mem_data), .cur_col(cur_col),
      .cur_bank(cur_bank)
   );

   typedef struct { int addr; int data; } item_t;
   item_t sb_q[$];

   int n_chk = 0, n_fail = 0;
   int m_col = 0, m_bank = 0;
   bit done = 0;
   logic due = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(posedge clk) due <= rst_n & wr_req;

   always @(negedge clk) begin
      if (rst_n) begin
         if (due) begin
            if (sb_q.size() == 0) chk(0, "R4 unexpected write", 1, 0);
            else begin
               item_t it;
               it = sb_q.pop_front();
               chk(mem_we == 1'b1, "R4 mem_we", int'(mem_we), 1);
               chk(int'(mem_addr) == it.addr, "R4 mem_addr", int'(mem_addr), it.addr);
               chk(int'(mem_data) == it.data, "R4 mem_data", int'(mem_data), it.data);
            end
         end else begin
            chk(mem_we == 1'b0, "R8 mem_we idle", int'(mem_we), 0);
         end
      end
   end

   function automatic void model_step(input bit bank_first);
      if (!bank_first) begin
         if (m_col == 100) begin m_col = 0; m_bank = (m_bank == 4) ? 0 : m_bank + 1; end
         else m_col++;
      end else begin
         if (m_bank == 4) begin m_bank = 0; m_col = (m_col == 100) ? 0 : m_col + 1; end
         else m_bank++;
      end
   endfunction

   task automatic push_write(input int d);
      item_t it;
      it.addr = m_bank * 101 + m_col;
      it.data = d;
      sb_q.push_back(it);
   endtask

   task automatic load_col(input int v);
      @(posedge clk); #1;
      ld_col = 1'b1; col_in = 7'(v);
      @(posedge clk); #1;
      ld_col = 1'b0;
      m_col = (v > 100) ? 0 : v;
   endtask

   task automatic load_bank(input int v);
      @(posedge clk); #1;
      ld_bank = 1'b1; bank_in = 3'(v);
      @(posedge clk); #1;
      ld_bank = 1'b0;
      m_bank = (v > 4) ? 0 : v;
   endtask

   task automatic burst(input bit bank_first, input int n, input int seed);
      @(posedge clk); #1;
      step_dir = bank_first;
      for (int i = 0; i < n; i++) begin
         wr_req = 1'b1; wr_data = 8'(seed + i * 7);
         push_write(seed + i * 7 & 255);
         model_step(bank_first);
         @(posedge clk); #1;
      end
      wr_req = 1'b0;
   endtask

   task automatic chk_pos(input string tag);
      @(negedge clk);
      chk(int'(cur_col) == m_col, {tag, " column"}, int'(cur_col), m_col);
      chk(int'(cur_bank) == m_bank, {tag, " bank"}, int'(cur_bank), m_bank);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      // R1: reset state
      @(negedge clk);
      chk(cur_col == 0, "R1 column", int'(cur_col), 0);
      chk(cur_bank == 0, "R1 bank", int'(cur_bank), 0);
      chk(mem_we == 0, "R1 mem_we", int'(mem_we), 0);
      @(posedge clk); #1 rst_n = 1'b1;

      // R2 column loads
      load_col(37);  chk_pos("R2 load 37");
      load_col(120); chk_pos("R2 clamp 120");
      load_col(100); chk_pos("R2 load 100");
      // R3 bank loads
      load_bank(3); chk_pos("R3 load 3");
      load_bank(6); chk_pos("R3 clamp 6");
      load_bank(4); chk_pos("R3 load 4");

      // R5 column-first across a bank boundary
      load_col(98); load_bank(1);
      burst(1'b0, 5, 16);
      chk_pos("R5 column first");

      // R6 bank-first across a column boundary
      load_col(7); load_bank(3);
      burst(1'b1, 4, 40);
      chk_pos("R6 bank first");

      // R7 corner wrap in both orders
      load_col(100); load_bank(4);
      burst(1'b0, 2, 90);
      chk_pos("R7 wrap column first");
      load_col(100); load_bank(3);
      burst(1'b1, 3, 120);
      chk_pos("R7 wrap bank first");

      // R7 full sweeps return to start
      load_col(12); load_bank(2);
      burst(1'b0, 505, 3);
      chk_pos("R7 sweep column first");
      burst(1'b1, 505, 5);
      chk_pos("R7 sweep bank first");

      // R8 idle holds position
      repeat (6) @(posedge clk);
      chk_pos("R8 idle hold");

      // R9 load together with a write
      load_col(5); load_bank(2);
      @(posedge clk); #1;
      step_dir = 1'b0;
      wr_req = 1'b1; wr_data = 8'hA5; ld_col = 1'b1; col_in = 7'd50;
      push_write(8'hA5);
      m_col = 50;
      @(posedge clk); #1;
      wr_req = 1'b0; ld_col = 1'b0;
      chk_pos("R9 load with write");

      repeat (3) @(posedge clk);
      chk(sb_q.size() == 0, "R4 pending writes", sb_q.size(), 0);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule